// File: doc/BRIEF.md
# Accumulator Multiply-Divide and Double-Word Shift Unit

This block is a sequential arithmetic helper that owns a 12-bit accumulator (AC), a 1-bit link (L), a 12-bit multiplier-quotient word (MQ) and a 5-bit step counter (SC). A host hands it commands on a valid/ready command channel. A command carries register-move flags and an operation code. Multiply, divide and the three shifts also need a 12-bit word, which arrives on a separate valid/ready operand channel once the command has been taken. Normalize needs no word. The block does one add, subtract or shift step per clock.

Back-pressure works as follows. The command channel is ready only while the unit is idle. The operand channel is ready only while the unit waits for the word of an accepted command. Either side may hold its valid low for as long as it likes, and nothing changes while it does. Each accepted command produces exactly one `done` pulse, on the cycle its results are visible at the register outputs. While `busy` is low, the host can load AC and L directly through plain write strobes.

Top module: `eae_unit`

## Requirements
- R1: After reset, ac, mq, link and sc are zero, busy and done are low, cmd_ready is high and opnd_ready is low.
- R2: ac_wr and link_wr load AC and L when the unit is idle, and are ignored while busy is high.
- R3: At command acceptance, the moves are applied in this order. First, cmd_clr_ac clears AC. Then cmd_ac_to_mq copies that AC into MQ and zeroes AC. Finally, cmd_mq_to_ac ORs the old MQ into AC and cmd_sc_to_ac ORs the zero-extended SC into AC. A command with op 0 (none) or 7 (reserved) does only the moves.
- R4: Op 1 (multiply) leaves the unsigned 24-bit product of MQ and the operand in AC (upper half) and MQ (lower half). L is unchanged.
- R5: Op 2 (divide) with AC below the divisor leaves the quotient of the 24-bit value AC:MQ in MQ and the remainder in AC, and clears L.
- R6: Op 2 with AC greater than or equal to the divisor (this includes a zero divisor) sets L, leaves AC and MQ unchanged, and completes after one run cycle.
- R7: Op 3 (normalize) clears L and SC, then shifts AC:MQ left with zero fill until AC bit 11 differs from AC bit 10 or SC reaches 23. SC holds the number of shifts.
- R8: Op 4 (shift left) moves AC:MQ left by operand+1 places with zero fill. L is unchanged.
- R9: Op 5 (arithmetic right shift) moves AC:MQ right by operand+1 places, filling with AC bit 11. Bits leaving MQ bit 0 are lost and L is unchanged.
- R10: Op 6 (logical right shift) moves AC:MQ right by operand+1 places with zero fill. L is unchanged.
- R11: A shift whose operand is 23 or more gives the same result as a shift of 24 places and takes 24 run cycles.
- R12: cmd_ready equals not busy. After an operand-taking command is accepted, opnd_ready and busy are high until the operand is taken. AC and MQ hold while the operand is awaited.
- R13: done pulses once per accepted command. For a moves-only command it pulses at the acceptance edge. For normalize it pulses n+1 edges after acceptance, where n is the number of shifts. For the other ops it pulses after the operand edge: 12 edges later for multiply and a completing divide, 1 edge later for an overflowing divide, and min(operand+1,24) edges later for a shift. busy is low whenever done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_clr_ac | input | 1 | Clear AC first |
| cmd_mq_to_ac | input | 1 | OR MQ into AC |
| cmd_sc_to_ac | input | 1 | OR SC into AC |
| cmd_ac_to_mq | input | 1 | Move AC into MQ, then zero AC |
| cmd_op | input | 3 | Operation code (0 none, 1 mul, 2 div, 3 normalize, 4 shl, 5 asr, 6 lsr) |
| opnd_valid | input | 1 | Operand word offered |
| opnd_ready | output | 1 | Unit waits for an operand |
| opnd_data | input | 12 | Operand word: multiplier, divisor or shift count |
| ac_wr | input | 1 | Host load of AC (idle only) |
| ac_wdata | input | 12 | Value for host AC load |
| link_wr | input | 1 | Host load of L (idle only) |
| link_wdata | input | 1 | Value for host L load |
| ac | output | 12 | Accumulator |
| link | output | 1 | Link bit |
| mq | output | 12 | Multiplier-quotient word |
| sc | output | 5 | Step counter |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when a command's results are visible |

## Verification
Each result is due at a fixed edge, measured from the handshake that starts it. A moves-only command finishes on its own acceptance edge. Normalize finishes one edge after its last shift. Multiply, divide and the shifts count from the operand edge: 12 edges for multiply and a completing divide, 1 edge for an overflowing divide, and the clamped count for a shift. When the bench offers a command or operand, it already knows the edge that will take it, so it queues the predicted register values together with that due edge. A monitor samples on falling edges. When done is high, it compares AC, MQ, L and SC against the queued item and also checks that the current edge number equals the due edge. Early or late completion is therefore caught as well as a wrong value.

// File: rtl/eae_pkg.sv
package eae_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_MUL  = 3'd1,
    OP_DIV  = 3'd2,
    OP_NORM = 3'd3,
    OP_SHL  = 3'd4,
    OP_ASR  = 3'd5,
    OP_LSR  = 3'd6,
    OP_RSV  = 3'd7
  } eae_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } eae_state_e;

  function automatic logic op_takes_word(eae_op_e op);
    return (op == OP_MUL) || (op == OP_DIV) || (op == OP_SHL) ||
           (op == OP_ASR) || (op == OP_LSR);
  endfunction

endpackage

// File: rtl/eae_ctrl.sv
module eae_ctrl
  import eae_pkg::*;
#(
  parameter int W    = 12,
  parameter int CNTW = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  eae_op_e      op_in,
  input  logic         opnd_valid,
  input  logic [W-1:0] opnd_data,
  input  logic         early_stop,
  output logic         cmd_ready,
  output logic         opnd_ready,
  output logic         cmd_fire,
  output logic         opnd_fire,
  output logic         run,
  output logic         first,
  output eae_op_e      op_q,
  output logic         busy,
  output logic         done
);
  localparam int W2 = 2 * W;

  eae_state_e         state_q;
  logic [CNTW-1:0]    cnt_q;
  logic [CNTW-1:0]    shift_cnt;
  logic               last;

  assign cmd_ready  = (state_q == ST_IDLE);
  assign opnd_ready = (state_q == ST_WAIT);
  assign run        = (state_q == ST_RUN);
  assign busy       = (state_q != ST_IDLE);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign opnd_fire  = opnd_valid && opnd_ready;

  // shifts beyond the word pair width are clamped to a full clear-out
  assign shift_cnt = (opnd_data >= W'(W2 - 1)) ? CNTW'(W2)
                                               : opnd_data[CNTW-1:0] + CNTW'(1);

  assign last = run && (early_stop || ((op_q != OP_NORM) && (cnt_q == CNTW'(1))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      first   <= 1'b0;
      op_q    <= OP_NONE;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cmd_fire) begin
          op_q <= op_in;
          if (op_in == OP_NORM)          state_q <= ST_RUN;
          else if (op_takes_word(op_in)) state_q <= ST_WAIT;
          else                           done    <= 1'b1;
        end
        ST_WAIT: if (opnd_fire) begin
          state_q <= ST_RUN;
          first   <= 1'b1;
          cnt_q   <= ((op_q == OP_MUL) || (op_q == OP_DIV)) ? CNTW'(W) : shift_cnt;
        end
        ST_RUN: begin
          first <= 1'b0;
          cnt_q <= cnt_q - CNTW'(1);
          if (last) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eae_muldiv_step.sv
module eae_muldiv_step #(
  parameter int W = 12
) (
  input  logic [W-1:0] ac,
  input  logic [W-1:0] mq,
  input  logic [W-1:0] dvs,
  input  logic         is_div,
  output logic [W-1:0] ac_n,
  output logic [W-1:0] mq_n,
  output logic         ovf
);
  logic [W:0] sum;
  logic [W:0] rem;
  logic [W:0] diff;
  logic       fits;

  // multiply: conditional add then right shift of carry:AC:MQ
  assign sum  = {1'b0, ac} + (mq[0] ? {1'b0, dvs} : '0);
  // divide: restoring step on partial remainder
  assign rem  = {ac, mq[W-1]};
  assign fits = (rem >= {1'b0, dvs});
  assign diff = rem - {1'b0, dvs};
  assign ovf  = (ac >= dvs);

  always_comb begin
    if (is_div) begin
      ac_n = fits ? diff[W-1:0] : rem[W-1:0];
      mq_n = {mq[W-2:0], fits};
    end else begin
      ac_n = sum[W:1];
      mq_n = {sum[0], mq[W-1:1]};
    end
  end
endmodule

// File: rtl/eae_shift_step.sv
module eae_shift_step
  import eae_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] ac,
  input  logic [W-1:0] mq,
  input  eae_op_e      mode,
  output logic [W-1:0] ac_n,
  output logic [W-1:0] mq_n
);
  logic [2*W-1:0] pair;
  logic [2*W-1:0] pair_n;

  assign pair = {ac, mq};

  always_comb begin
    unique case (mode)
      OP_SHL, OP_NORM: pair_n = {pair[2*W-2:0], 1'b0};
      OP_ASR:          pair_n = {pair[2*W-1], pair[2*W-1:1]};
      OP_LSR:          pair_n = {1'b0, pair[2*W-1:1]};
      default:         pair_n = pair;
    endcase
  end

  assign ac_n = pair_n[2*W-1:W];
  assign mq_n = pair_n[W-1:0];
endmodule

// File: rtl/eae_unit.sv
module eae_unit
  import eae_pkg::*;
#(
  parameter int W   = 12,
  parameter int SCW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_clr_ac,
  input  logic           cmd_mq_to_ac,
  input  logic           cmd_sc_to_ac,
  input  logic           cmd_ac_to_mq,
  input  logic [2:0]     cmd_op,
  input  logic           opnd_valid,
  output logic           opnd_ready,
  input  logic [W-1:0]   opnd_data,
  input  logic           ac_wr,
  input  logic [W-1:0]   ac_wdata,
  input  logic           link_wr,
  input  logic           link_wdata,
  output logic [W-1:0]   ac,
  output logic           link,
  output logic [W-1:0]   mq,
  output logic [SCW-1:0] sc,
  output logic           busy,
  output logic           done
);
  localparam int CNTW = $clog2(2 * W + 1);
  localparam logic [SCW-1:0] NORM_MAX = SCW'(2 * W - 1);

  logic [W-1:0]   ac_q, mq_q, dvs_q;
  logic           link_q;
  logic [SCW-1:0] sc_q;

  logic           cmd_fire, opnd_fire, run, first, early_stop, norm_stop, ovf;
  eae_op_e        op_q;
  logic [W-1:0]   md_ac, md_mq, sh_ac, sh_mq;
  logic [W-1:0]   ac_base, ac_moved;

  assign norm_stop  = (ac_q[W-1] != ac_q[W-2]) || (sc_q == NORM_MAX);
  assign early_stop = ((op_q == OP_NORM) && norm_stop) ||
                      ((op_q == OP_DIV) && first && ovf);

  eae_ctrl #(.W(W), .CNTW(CNTW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .op_in      (eae_op_e'(cmd_op)),
    .opnd_valid (opnd_valid),
    .opnd_data  (opnd_data),
    .early_stop (early_stop),
    .cmd_ready  (cmd_ready),
    .opnd_ready (opnd_ready),
    .cmd_fire   (cmd_fire),
    .opnd_fire  (opnd_fire),
    .run        (run),
    .first      (first),
    .op_q       (op_q),
    .busy       (busy),
    .done       (done)
  );

  eae_muldiv_step #(.W(W)) u_md (
    .ac     (ac_q),
    .mq     (mq_q),
    .dvs    (dvs_q),
    .is_div (op_q == OP_DIV),
    .ac_n   (md_ac),
    .mq_n   (md_mq),
    .ovf    (ovf)
  );

  eae_shift_step #(.W(W)) u_sh (
    .ac   (ac_q),
    .mq   (mq_q),
    .mode (op_q),
    .ac_n (sh_ac),
    .mq_n (sh_mq)
  );

  // first time slot: clear; second slot: loads into AC and MQ
  assign ac_base  = cmd_clr_ac ? '0 : ac_q;
  assign ac_moved = (cmd_ac_to_mq ? '0 : ac_base) |
                    (cmd_mq_to_ac ? mq_q : '0) |
                    (cmd_sc_to_ac ? {{(W-SCW){1'b0}}, sc_q} : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q   <= '0;
      mq_q   <= '0;
      dvs_q  <= '0;
      link_q <= 1'b0;
      sc_q   <= '0;
    end else begin
      if (!busy && ac_wr)   ac_q   <= ac_wdata;
      if (!busy && link_wr) link_q <= link_wdata;
      if (cmd_fire) begin
        ac_q <= ac_moved;
        if (cmd_ac_to_mq) mq_q <= ac_base;
        if (eae_op_e'(cmd_op) == OP_NORM) begin
          sc_q   <= '0;
          link_q <= 1'b0;
        end
      end
      if (opnd_fire) begin
        dvs_q <= opnd_data;
        if (op_q == OP_MUL) ac_q <= '0;
      end
      if (run) begin
        unique case (op_q)
          OP_MUL: begin
            ac_q <= md_ac;
            mq_q <= md_mq;
          end
          OP_DIV: begin
            if (first && ovf) begin
              link_q <= 1'b1;
            end else begin
              ac_q   <= md_ac;
              mq_q   <= md_mq;
              link_q <= 1'b0;
            end
          end
          OP_NORM: if (!norm_stop) begin
            ac_q <= sh_ac;
            mq_q <= sh_mq;
            sc_q <= sc_q + SCW'(1);
          end
          OP_SHL, OP_ASR, OP_LSR: begin
            ac_q <= sh_ac;
            mq_q <= sh_mq;
          end
          default: ;
        endcase
      end
    end
  end

  assign ac   = ac_q;
  assign mq   = mq_q;
  assign link = link_q;
  assign sc   = sc_q;
endmodule

// File: rtl/eae_unit_checker.sv
module eae_unit_checker
  import eae_pkg::*;
#(
  parameter int W   = 12,
  parameter int SCW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [2:0]     cmd_op,
  input logic           opnd_valid,
  input logic           opnd_ready,
  input logic           busy,
  input logic           done,
  input logic           run,
  input logic           first,
  input logic [2:0]     op_q,
  input logic [W-1:0]   dvs,
  input logic [W-1:0]   ac,
  input logic [W-1:0]   mq,
  input logic           link,
  input logic [SCW-1:0] sc
);
  localparam logic [SCW-1:0] NORM_MAX = SCW'(2 * W - 1);

  assert_opnd_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_ready |-> busy);

  assert_cmd_to_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && op_takes_word(eae_op_e'(cmd_op))) |=> opnd_ready);

  assert_wait_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_ready && !opnd_valid) |=> ($stable(ac) && $stable(mq) && $stable(link)));

  assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_sc_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sc <= NORM_MAX);

  assert_shift_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (op_q == OP_SHL || op_q == OP_ASR || op_q == OP_LSR)) |=> $stable(link));

  assert_div_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op_q == OP_DIV && first && ac >= dvs) |=>
      (link && done && $stable(ac) && $stable(mq)));
endmodule

bind eae_unit eae_unit_checker #(.W(W), .SCW(SCW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .opnd_valid (opnd_valid),
  .opnd_ready (opnd_ready),
  .busy       (busy),
  .done       (done),
  .run        (run),
  .first      (first),
  .op_q       (op_q),
  .dvs        (dvs_q),
  .ac         (ac),
  .mq         (mq),
  .link       (link),
  .sc         (sc)
);

// File: tb/eae_unit_bench.sv
module eae_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_clr_ac = 0, cmd_mq_to_ac = 0, cmd_sc_to_ac = 0, cmd_ac_to_mq = 0;
  logic [2:0]  cmd_op = 0;
  logic        opnd_valid = 0;
  logic [11:0] opnd_data = 0;
  logic        ac_wr = 0, link_wr = 0, link_wdata = 0;
  logic [11:0] ac_wdata = 0;
  logic        cmd_ready, opnd_ready, link, busy, done;
  logic [11:0] ac, mq;
  logic [4:0]  sc;

  always #10 clk = ~clk;

  eae_unit u_eae_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_clr_ac(cmd_clr_ac), .cmd_mq_to_ac(cmd_mq_to_ac), .cmd_sc_to_ac(cmd_sc_to_ac),
    .cmd_ac_to_mq(cmd_ac_to_mq), .cmd_op(cmd_op), .opnd_valid(opnd_valid),
    .opnd_ready(opnd_ready), .opnd_data(opnd_data), .ac_wr(ac_wr), .ac_wdata(ac_wdata),
    .link_wr(link_wr), .link_wdata(link_wdata), .ac(ac), .link(link), .mq(mq),
    .sc(sc), .busy(busy), .done(done)
  );

  typedef struct {
    logic [11:0] ac;
    logic [11:0] mq;
    logic        l;
    logic [4:0]  sc;
    int          due;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic [11:0] m_ac = 0, m_mq = 0;
  logic        m_l = 0;
  logic [4:0]  m_sc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R13 done with nothing pending: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.req, "ac", 32'(ac), 32'(e.ac));
        chk(e.req, "mq", 32'(mq), 32'(e.mq));
        chk(e.req, "link", 32'(link), 32'(e.l));
        chk(e.req, "sc", 32'(sc), 32'(e.sc));
        chk("R13", "done edge", 32'(cyc), 32'(e.due));
      end
    end
  end

  task automatic push(input int due, input string req);
    exp_t e;
    e.ac = m_ac; e.mq = m_mq; e.l = m_l; e.sc = m_sc; e.due = due; e.req = req;
    sb.push_back(e);
  endtask

  task automatic host_write(input logic [11:0] a, input logic l);
    @(negedge clk);
    ac_wr = 1; ac_wdata = a; link_wr = 1; link_wdata = l;
    @(negedge clk);
    ac_wr = 0; link_wr = 0;
    m_ac = a; m_l = l;
  endtask

  task automatic run_cmd(input logic clr, input logic mqa, input logic sca, input logic mql,
                         input logic [2:0] op, input logic [11:0] v, input int gap,
                         input string req);
    logic [11:0] base;
    logic [11:0] nac;
    logic [23:0] pair;
    int          a_edge;
    int          lat;
    int          n;
    bit          word;
    word = (op == 1) || (op == 2) || (op == 4) || (op == 5) || (op == 6);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    base = clr ? 12'h000 : m_ac;
    nac  = (mql ? 12'h000 : base) | (mqa ? m_mq : 12'h000) | (sca ? {7'b0, m_sc} : 12'h000);
    if (mql) m_mq = base;
    m_ac = nac;
    a_edge = cyc + 1;
    cmd_valid = 1; cmd_clr_ac = clr; cmd_mq_to_ac = mqa; cmd_sc_to_ac = sca;
    cmd_ac_to_mq = mql; cmd_op = op;
    if (op == 3) begin
      m_l = 0; m_sc = 0; n = 0;
      while (m_sc < 5'd23 && m_ac[11] == m_ac[10]) begin
        pair = {m_ac, m_mq} << 1;
        m_ac = pair[23:12]; m_mq = pair[11:0];
        m_sc++; n++;
      end
      push(a_edge + n + 1, req);
    end else if (!word) begin
      push(a_edge, req);
    end
    @(negedge clk);
    cmd_valid = 0; cmd_clr_ac = 0; cmd_mq_to_ac = 0; cmd_sc_to_ac = 0;
    cmd_ac_to_mq = 0; cmd_op = 0;
    if (word) begin
      chk("R12", "busy while waiting", 32'(busy), 32'd1);
      chk("R12", "cmd_ready while waiting", 32'(cmd_ready), 32'd0);
      chk("R12", "opnd_ready while waiting", 32'(opnd_ready), 32'd1);
      if (gap > 0) begin
        // host writes during the wait must have no effect (R2)
        ac_wr = 1; ac_wdata = ~m_ac; link_wr = 1; link_wdata = ~m_l;
        @(negedge clk);
        ac_wr = 0; link_wr = 0;
        repeat (gap - 1) @(negedge clk);
      end
      pair = {m_ac, m_mq};
      case (op)
        3'd1: begin
          pair = 24'(m_mq) * 24'(v);
          m_ac = pair[23:12]; m_mq = pair[11:0]; lat = 12;
        end
        3'd2: begin
          if (m_ac >= v) begin
            m_l = 1; lat = 1;
          end else begin
            m_mq = 12'(pair / 24'(v)); m_ac = 12'(pair % 24'(v)); m_l = 0; lat = 12;
          end
        end
        default: begin
          lat = (v >= 12'd23) ? 24 : int'(v) + 1;
          for (int i = 0; i < lat; i++) begin
            if (op == 3'd4)      pair = pair << 1;
            else if (op == 3'd5) pair = {pair[23], pair[23:1]};
            else                 pair = pair >> 1;
          end
          m_ac = pair[23:12]; m_mq = pair[11:0];
        end
      endcase
      push(cyc + 1 + lat, req);
      opnd_valid = 1; opnd_data = v;
      @(negedge clk);
      opnd_valid = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_acmq(input logic [11:0] a, input logic [11:0] m, input logic l);
    host_write(m, l);
    run_cmd(0, 0, 0, 1, 3'd0, 12'h000, 0, "R3");
    host_write(a, l);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ac", 32'(ac), 0);
    chk("R1", "mq", 32'(mq), 0);
    chk("R1", "link", 32'(link), 0);
    chk("R1", "sc", 32'(sc), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "cmd_ready", 32'(cmd_ready), 1);
    chk("R1", "opnd_ready", 32'(opnd_ready), 0);

    host_write(12'h123, 1'b1);
    run_cmd(0, 0, 0, 0, 3'd0, 0, 0, "R2");
    run_cmd(0, 0, 0, 1, 3'd7, 0, 0, "R3");
    host_write(12'h0F0, 1'b0);
    run_cmd(0, 1, 0, 0, 3'd0, 0, 0, "R3");
    run_cmd(1, 1, 0, 0, 3'd0, 0, 0, "R3");

    set_acmq(12'h000, 12'h00F, 1'b1);
    run_cmd(0, 0, 0, 0, 3'd1, 12'h0AB, 0, "R4");
    set_acmq(12'h555, 12'hFFF, 1'b0);
    run_cmd(0, 0, 0, 0, 3'd1, 12'hFFF, 3, "R4");

    set_acmq(12'h012, 12'h345, 1'b1);
    run_cmd(0, 0, 0, 0, 3'd2, 12'h100, 0, "R5");
    set_acmq(12'h0FF, 12'hFFF, 1'b1);
    run_cmd(0, 0, 0, 0, 3'd2, 12'h100, 2, "R5");
    set_acmq(12'h100, 12'h777, 1'b0);
    run_cmd(0, 0, 0, 0, 3'd2, 12'h100, 0, "R6");
    set_acmq(12'h000, 12'h001, 1'b0);
    run_cmd(0, 0, 0, 0, 3'd2, 12'h000, 0, "R6");

    set_acmq(12'h001, 12'h000, 1'b1);
    run_cmd(0, 0, 0, 0, 3'd3, 0, 0, "R7");
    run_cmd(1, 0, 1, 0, 3'd0, 0, 0, "R3");
    set_acmq(12'h000, 12'h000, 1'b1);
    run_cmd(0, 0, 0, 0, 3'd3, 0, 0, "R7");
    set_acmq(12'h400, 12'h123, 1'b0);
    run_cmd(0, 0, 0, 0, 3'd3, 0, 0, "R7");
    set_acmq(12'hFFF, 12'hFFF, 1'b0);
    run_cmd(0, 0, 0, 0, 3'd3, 0, 0, "R7");

    set_acmq(12'h0A5, 12'hC3C, 1'b1);
    run_cmd(0, 0, 0, 0, 3'd4, 12'd3, 0, "R8");
    set_acmq(12'h0A5, 12'hC3C, 1'b0);
    run_cmd(0, 0, 0, 0, 3'd4, 12'hFFF, 0, "R11");
    set_acmq(12'h800, 12'h001, 1'b1);
    run_cmd(0, 0, 0, 0, 3'd5, 12'd1, 1, "R9");
    set_acmq(12'h9AB, 12'hCDE, 1'b0);
    run_cmd(0, 0, 0, 0, 3'd5, 12'd30, 0, "R11");
    set_acmq(12'h800, 12'h003, 1'b1);
    run_cmd(0, 0, 0, 0, 3'd6, 12'd0, 0, "R10");
    set_acmq(12'hF00, 12'h00F, 1'b0);
    run_cmd(0, 0, 0, 0, 3'd6, 12'd22, 0, "R10");

    repeat (3) @(negedge clk);
    chk("R13", "pending completions", 32'(sb.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R13 watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule